// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. While capture is on, it stores a stream of 32-bit trace words into an internal ring of `DEPTH` words. Software reaches the ring and the control state over a simple single-cycle register bus. Two registers act as access ports into the RAM. Reading the data port returns the word at the read pointer and then steps that pointer. Writing the data port stores a word at the write pointer and then steps that pointer. Both pointers are word indices and software may load them at any time.

The capture path has three control features on top of a plain ring.

- A sticky full flag records that the write pointer has wrapped. Once it is set, the oldest surviving word is the one at the write pointer.
- A post-trigger countdown lets a set number of words in after a trigger pulse and then halts capture.
- A self-clearing manual flush can optionally halt capture when it completes.

Data is grouped in frames of four words. When framing is enabled, every flush or halt first pads the current partial frame with zero words, so the write pointer ends on a frame boundary.

A typical session runs in this order:

1. Clear the ring through the data port.
2. Zero the pointers and program the post-trigger count and the halt modes.
3. Enable capture.
4. Later, request a flush that halts the block.
5. Wait for the halted status, then read the ring back starting from the write pointer if the full flag is set, or from zero if it is not.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, both pointers are 0, the status register is 0 and the control register is 0. The depth register (byte offset 0x004) reads DEPTH. The formatter status register (0x300) reads 0x2. Register byte offsets: 0x00C status, 0x010 read port, 0x014 read pointer, 0x018 write pointer, 0x01C trigger count, 0x020 control, 0x024 write port, 0x304 formatter control.
- R2: A write to the write port (0x024) stores the data at the write pointer and advances the write pointer by one, wrapping from DEPTH-1 to 0.
- R3: A read of the read port (0x010) returns the word at the read pointer in the same cycle and advances the read pointer by one, wrapping at DEPTH. Both pointers are loadable by bus write.
- R4: A trace word is accepted only in a cycle where trc_valid_i and trc_ready_o are both high. When accepted, it is written at the write pointer. trc_ready_o is low while control bit 0 is 0. Words offered while it is low change nothing.
- R5: Status bit 0 (full) sets when any RAM write occurs with the write pointer at DEPTH-1. It stays set across further writes. It is cleared by a bus write of the write pointer, or by a control write with bit 0 equal to 0.
- R6: Writing formatter control with bit 6 set, or a pulse on flush_i, starts a flush. Bit 6 reads 1 until the flush completes and then clears itself. No trace word is accepted while a flush is pending.
- R7: With formatter control bit 0 (framing) set, a flush or a halt writes zero words until the write pointer is a multiple of 4. Only then does it complete.
- R8: With formatter control bit 12 set, completion of a flush halts capture. Formatter status bit 1 then reads 1 and trc_ready_o stays low.
- R9: With formatter control bit 13 set, the first trigger pulse while capture is enabled loads the trigger count register. Exactly that many further words are accepted, and then capture halts. A count of 0 halts with no further words.
- R10: Trigger pulses after the first are ignored until the trigger state is re-armed by a control write or a write-pointer write.
- R11: With framing off (formatter control bit 0 clear), a halt or flush completes without any padding words.
- R12: Formatter status bit 1 reads 1 whenever control bit 0 is 0. Formatter status bit 0 mirrors the pending flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access strobe, one access per cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 12 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| trc_valid_i | input | 1 | Trace word offered |
| trc_data_i | input | 32 | Trace word |
| trc_ready_o | output | 1 | Trace word accepted when high together with valid |
| trig_i | input | 1 | Trigger pulse |
| flush_i | input | 1 | External flush request pulse |

## Verification
The bound checker watches the invariants that must hold in every cycle:

- no acceptance while capture is off, halted or flushing;
- pointer motion limited to single steps or bus loads;
- the full flag rising only on a write at the last slot;
- every halt under framing landing on a frame boundary.

Only the directed scenarios can show the quantities involved: the exact number of words let in after a trigger, the zero contents of padded slots, that a second trigger pulse is ignored, the self-clearing of the flush bit, and the ordering of wrapped data read back from the write pointer.

// File: rtl/tsink_pkg.sv
package tsink_pkg;
  localparam int FRAME_WORDS = 4;

  localparam logic [11:0] OFF_DEPTH = 12'h004;
  localparam logic [11:0] OFF_STAT  = 12'h00C;
  localparam logic [11:0] OFF_RDATA = 12'h010;
  localparam logic [11:0] OFF_RPTR  = 12'h014;
  localparam logic [11:0] OFF_WPTR  = 12'h018;
  localparam logic [11:0] OFF_TRG   = 12'h01C;
  localparam logic [11:0] OFF_CTL   = 12'h020;
  localparam logic [11:0] OFF_WDATA = 12'h024;
  localparam logic [11:0] OFF_FSTAT = 12'h300;
  localparam logic [11:0] OFF_FCTL  = 12'h304;

  localparam int FC_FMT_EN   = 0;
  localparam int FC_FLUSH    = 6;
  localparam int FC_STOP_FL  = 12;
  localparam int FC_STOP_TRG = 13;

  typedef struct packed {
    logic fmt_en;
    logic stop_fl;
    logic stop_trg;
  } fctl_t;
endpackage

// File: rtl/tsink_regs.sv
module tsink_regs
  import tsink_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TRG_W = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             ctl_en_o,
  output logic [TRG_W-1:0] trg_val_o,
  output fctl_t            fctl_o,
  output logic             wr_wdata_o,
  output logic             wr_wptr_o,
  output logic             wr_rptr_o,
  output logic             rd_port_o,
  output logic             flush_set_o,
  output logic             full_clr_o,
  output logic             state_clr_o,
  input  logic             full_i,
  input  logic [31:0]      ram_q_i,
  input  logic [AW-1:0]    rptr_i,
  input  logic [AW-1:0]    wptr_i,
  input  logic             flush_i,
  input  logic             stopped_i
);
  logic wr, rd, wr_ctl, wr_trg, wr_fctl;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign wr_ctl  = wr && addr_i == OFF_CTL;
  assign wr_trg  = wr && addr_i == OFF_TRG;
  assign wr_fctl = wr && addr_i == OFF_FCTL;

  assign wr_wdata_o  = wr && addr_i == OFF_WDATA;
  assign wr_wptr_o   = wr && addr_i == OFF_WPTR;
  assign wr_rptr_o   = wr && addr_i == OFF_RPTR;
  assign rd_port_o   = rd && addr_i == OFF_RDATA;
  assign flush_set_o = wr_fctl & wdata_i[FC_FLUSH];
  assign full_clr_o  = wr_wptr_o | (wr_ctl & ~wdata_i[0]);
  assign state_clr_o = wr_wptr_o | wr_ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_en_o  <= 1'b0;
      trg_val_o <= '0;
      fctl_o    <= '0;
    end else begin
      if (wr_ctl) ctl_en_o <= wdata_i[0];
      if (wr_trg) trg_val_o <= wdata_i[TRG_W-1:0];
      if (wr_fctl) begin
        fctl_o.fmt_en   <= wdata_i[FC_FMT_EN];
        fctl_o.stop_fl  <= wdata_i[FC_STOP_FL];
        fctl_o.stop_trg <= wdata_i[FC_STOP_TRG];
      end
    end
  end

  logic fmt_stopped;
  assign fmt_stopped = stopped_i | ~ctl_en_o;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFF_DEPTH: rdata_o = 32'(DEPTH);
        OFF_STAT:  rdata_o = {31'b0, full_i};
        OFF_RDATA: rdata_o = ram_q_i;
        OFF_RPTR:  rdata_o = 32'(rptr_i);
        OFF_WPTR:  rdata_o = 32'(wptr_i);
        OFF_TRG:   rdata_o = 32'(trg_val_o);
        OFF_CTL:   rdata_o = {31'b0, ctl_en_o};
        OFF_FSTAT: rdata_o = {30'b0, fmt_stopped, flush_i};
        OFF_FCTL: begin
          rdata_o[FC_FMT_EN]   = fctl_o.fmt_en;
          rdata_o[FC_FLUSH]    = flush_i;
          rdata_o[FC_STOP_FL]  = fctl_o.stop_fl;
          rdata_o[FC_STOP_TRG] = fctl_o.stop_trg;
        end
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tsink_ptrs.sv
module tsink_ptrs #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wptr_we_i,
  input  logic          rptr_we_i,
  input  logic [AW-1:0] ptr_val_i,
  input  logic          wr_adv_i,
  input  logic          rd_adv_i,
  input  logic          full_clr_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o <= '0;
      rptr_o <= '0;
      full_o <= 1'b0;
    end else begin
      if (wptr_we_i)     wptr_o <= ptr_val_i;
      else if (wr_adv_i) wptr_o <= (wptr_o == LAST) ? '0 : wptr_o + 1'b1;

      if (full_clr_i)                           full_o <= 1'b0;
      else if (wr_adv_i && wptr_o == LAST)      full_o <= 1'b1;

      if (rptr_we_i)     rptr_o <= ptr_val_i;
      else if (rd_adv_i) rptr_o <= (rptr_o == LAST) ? '0 : rptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/tsink_ram.sv
module tsink_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tsink_stopctl.sv
module tsink_stopctl
  import tsink_pkg::*;
#(
  parameter int TRG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_en_i,
  input  fctl_t            fctl_i,
  input  logic [TRG_W-1:0] trg_val_i,
  input  logic             state_clr_i,
  input  logic             trig_i,
  input  logic             flush_set_i,
  input  logic             acc_i,
  input  logic [1:0]       wlo_i,
  input  logic             bus_blk_i,
  output logic             take_o,
  output logic             pad_o,
  output logic             flush_o,
  output logic             stopped_o
);
  logic             stop_q, trig_seen_q;
  logic [TRG_W-1:0] left_q;
  logic             run, aligned, settle, flush_done;

  assign run     = ctl_en_i & ~stopped_o;
  assign aligned = ~fctl_i.fmt_en | (wlo_i == 2'd0);
  // completion may only be judged when the bus is not moving the write pointer
  assign settle  = aligned & ~bus_blk_i;

  assign take_o = run & ~flush_o & ~stop_q & ~bus_blk_i;
  assign pad_o  = run & fctl_i.fmt_en & (flush_o | stop_q) & (wlo_i != 2'd0) & ~bus_blk_i;

  assign flush_done = flush_o & ~flush_set_i & (~run | settle);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_o     <= 1'b0;
      stop_q      <= 1'b0;
      stopped_o   <= 1'b0;
      trig_seen_q <= 1'b0;
      left_q      <= '0;
    end else begin
      if (flush_set_i)     flush_o <= 1'b1;
      else if (flush_done) flush_o <= 1'b0;

      if (state_clr_i) begin
        stop_q      <= 1'b0;
        stopped_o   <= 1'b0;
        trig_seen_q <= 1'b0;
        left_q      <= '0;
      end else begin
        if (trig_i && ctl_en_i && !trig_seen_q && !stopped_o) begin
          trig_seen_q <= 1'b1;
          left_q      <= trg_val_i;
          if (fctl_i.stop_trg && trg_val_i == '0) stop_q <= 1'b1;
        end else if (trig_seen_q && acc_i && left_q != '0) begin
          left_q <= left_q - 1'b1;
          if (fctl_i.stop_trg && left_q == TRG_W'(1)) stop_q <= 1'b1;
        end

        if (stop_q && run && settle) begin
          stop_q    <= 1'b0;
          stopped_o <= 1'b1;
        end
        if (flush_done && run && fctl_i.stop_fl) stopped_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import tsink_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TRG_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [11:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        trc_valid_i,
  input  logic [31:0] trc_data_i,
  output logic        trc_ready_o,
  input  logic        trig_i,
  input  logic        flush_i
);
  localparam int AW = $clog2(DEPTH);

  logic             ctl_en;
  logic [TRG_W-1:0] trg_val;
  fctl_t            fctl;
  logic             wr_wdata, wptr_we, rptr_we, rd_adv, flush_set, full_clr, state_clr;
  logic             full, flush_pend, stopped, take, pad, acc, ram_we, bus_blk;
  logic [AW-1:0]    wptr, rptr;
  logic [31:0]      ram_q, ram_wd;

  assign bus_blk = wr_wdata | wptr_we;
  assign acc     = trc_valid_i & take;
  assign ram_we  = wr_wdata | pad | acc;
  assign ram_wd  = wr_wdata ? reg_wdata_i : (pad ? 32'h0 : trc_data_i);
  assign trc_ready_o = take;

  tsink_regs #(.DEPTH(DEPTH), .TRG_W(TRG_W), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .ctl_en_o(ctl_en), .trg_val_o(trg_val), .fctl_o(fctl),
    .wr_wdata_o(wr_wdata), .wr_wptr_o(wptr_we), .wr_rptr_o(rptr_we),
    .rd_port_o(rd_adv), .flush_set_o(flush_set),
    .full_clr_o(full_clr), .state_clr_o(state_clr),
    .full_i(full), .ram_q_i(ram_q), .rptr_i(rptr), .wptr_i(wptr),
    .flush_i(flush_pend), .stopped_i(stopped)
  );

  tsink_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk_i, .rst_ni,
    .wptr_we_i(wptr_we), .rptr_we_i(rptr_we), .ptr_val_i(reg_wdata_i[AW-1:0]),
    .wr_adv_i(ram_we), .rd_adv_i(rd_adv), .full_clr_i(full_clr),
    .wptr_o(wptr), .rptr_o(rptr), .full_o(full)
  );

  tsink_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i, .we_i(ram_we), .waddr_i(wptr), .wdata_i(ram_wd),
    .raddr_i(rptr), .rdata_o(ram_q)
  );

  tsink_stopctl #(.TRG_W(TRG_W)) u_stop (
    .clk_i, .rst_ni,
    .ctl_en_i(ctl_en), .fctl_i(fctl), .trg_val_i(trg_val),
    .state_clr_i(state_clr), .trig_i(trig_i),
    .flush_set_i(flush_set | flush_i), .acc_i(acc),
    .wlo_i(wptr[1:0]), .bus_blk_i(bus_blk),
    .take_o(take), .pad_o(pad), .flush_o(flush_pend), .stopped_o(stopped)
  );
endmodule

// File: rtl/tsink_chk.sv
module tsink_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctl_en,
  input logic          fmt_en,
  input logic          trc_ready,
  input logic          ram_we,
  input logic          wptr_we,
  input logic          rptr_we,
  input logic          rd_adv,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic          full,
  input logic          stopped,
  input logic          flush_pend
);
  assert_no_capture_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en |-> !trc_ready);

  assert_halt_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped |-> !trc_ready);

  assert_flush_blocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_pend |-> !trc_ready);

  assert_wptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && !wptr_we) |=> wptr == AW'($past(wptr) + 1'b1));

  assert_wptr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_we && !wptr_we) |=> $stable(wptr));

  assert_rptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_adv && !rptr_we) |=> rptr == AW'($past(rptr) + 1'b1));

  assert_full_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full) |-> ($past(ram_we) && $past(wptr) == AW'(DEPTH - 1)));

  assert_halt_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(stopped) && fmt_en) |-> wptr[1:0] == 2'd0);
endmodule

bind trace_ring_sink tsink_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_en(ctl_en), .fmt_en(fctl.fmt_en),
  .trc_ready(trc_ready_o), .ram_we(ram_we), .wptr_we(wptr_we), .rptr_we(rptr_we),
  .rd_adv(rd_adv), .wptr(wptr), .rptr(rptr), .full(full), .stopped(stopped),
  .flush_pend(flush_pend)
);

// File: tb/trace_ring_sink_tb_top.sv
`timescale 1ns/1ps
module trace_ring_sink_tb_top;
  localparam int DEPTH = 64;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDATA = 12'h010,
    A_RPTR = 12'h014, A_WPTR = 12'h018, A_TRG = 12'h01C, A_CTL = 12'h020,
    A_WDATA = 12'h024, A_FSTAT = 12'h300, A_FCTL = 12'h304;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, valid = 1'b0, trig = 1'b0, flush = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, tdata = '0, rdata;
  logic ready;
  int errors = 0, checks = 0, seq = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH), .TRG_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trc_valid_i(valid), .trc_data_i(tdata),
    .trc_ready_o(ready), .trig_i(trig), .flush_i(flush)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic push(input int tries, output int got);
    got = 0;
    for (int i = 0; i < tries; i++) begin
      logic acc;
      @(negedge clk); valid = 1'b1; tdata = 32'hA000_0000 + 32'(seq);
      #1 acc = ready;
      @(posedge clk);
      if (acc) begin got++; seq++; end
    end
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 depth", A_DEPTH, 32'(DEPTH));
    rd_chk("R1 status", A_STAT, 32'h0);
    rd_chk("R1 wptr", A_WPTR, 32'h0);
    rd_chk("R1 rptr", A_RPTR, 32'h0);
    rd_chk("R1 ctl", A_CTL, 32'h0);
    rd_chk("R1 fstat", A_FSTAT, 32'h2);
    chk("R1 ready", {31'b0, ready}, 32'h0);
  endtask

  task automatic t_sw_ram();
    wr(A_WPTR, 62);
    wr(A_WDATA, 32'h11); wr(A_WDATA, 32'h22); wr(A_WDATA, 32'h33); wr(A_WDATA, 32'h44);
    rd_chk("R2 wptr wrap", A_WPTR, 32'd2);
    rd_chk("R5 full by port write", A_STAT, 32'h1);
    wr(A_RPTR, 62);
    rd_chk("R3 word0", A_RDATA, 32'h11);
    rd_chk("R3 word1", A_RDATA, 32'h22);
    rd_chk("R3 word2", A_RDATA, 32'h33);
    rd_chk("R3 word3", A_RDATA, 32'h44);
    rd_chk("R3 rptr wrap", A_RPTR, 32'd2);
    wr(A_CTL, 0);
    rd_chk("R5 clear by ctl", A_STAT, 32'h0);
  endtask

  task automatic t_capture();
    int got, s0;
    wr(A_FCTL, 0); wr(A_CTL, 1); wr(A_WPTR, 10);
    s0 = seq;
    push(5, got);
    chk("R4 accepted", 32'(got), 32'd5);
    rd_chk("R4 wptr", A_WPTR, 32'd15);
    wr(A_RPTR, 10);
    for (int i = 0; i < 5; i++) rd_chk("R4 data", A_RDATA, 32'hA000_0000 + 32'(s0 + i));
    wr(A_CTL, 0);
    rd_chk("R12 fstat off", A_FSTAT, 32'h2);
    push(3, got);
    chk("R4 off ignored", 32'(got), 32'd0);
    rd_chk("R4 wptr kept", A_WPTR, 32'd15);
  endtask

  task automatic t_wrap();
    int got, s0;
    wr(A_CTL, 1); wr(A_WPTR, 0);
    s0 = seq;
    push(64, got);
    rd_chk("R5 wptr after ring", A_WPTR, 32'd0);
    rd_chk("R5 full set", A_STAT, 32'h1);
    push(3, got);
    rd_chk("R5 full sticky", A_STAT, 32'h1);
    wr(A_RPTR, 3);
    rd_chk("R5 oldest at wptr", A_RDATA, 32'hA000_0000 + 32'(s0 + 3));
    wr(A_WPTR, 0);
    rd_chk("R5 clear by wptr", A_STAT, 32'h0);
  endtask

  task automatic t_flush_stop();
    int got;
    wr(A_CTL, 0); wr(A_FCTL, 32'h1001); wr(A_CTL, 1); wr(A_WPTR, 0);
    push(5, got);
    wr(A_FCTL, 32'h1041);
    rd_chk("R6 flush pending", A_FCTL, 32'h1041);
    chk("R6 no accept while pending", {31'b0, ready}, 32'h0);
    idle(10);
    rd_chk("R6 flush self-clears", A_FCTL, 32'h1001);
    rd_chk("R7 padded wptr", A_WPTR, 32'd8);
    rd_chk("R8 halted status", A_FSTAT, 32'h2);
    wr(A_RPTR, 5);
    for (int i = 0; i < 3; i++) rd_chk("R7 pad zero", A_RDATA, 32'h0);
    push(3, got);
    chk("R8 no accept after halt", 32'(got), 32'd0);
  endtask

  task automatic t_ext_flush();
    int got;
    wr(A_CTL, 0); wr(A_FCTL, 32'h0001); wr(A_CTL, 1); wr(A_WPTR, 0);
    push(3, got);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    idle(6);
    rd_chk("R6 ext flush done", A_FCTL, 32'h0001);
    rd_chk("R7 ext flush pad", A_WPTR, 32'd4);
    rd_chk("R8 still running", A_FSTAT, 32'h0);
    push(2, got);
    chk("R6 resumes after flush", 32'(got), 32'd2);
  endtask

  task automatic t_trig();
    int got;
    wr(A_CTL, 0); wr(A_FCTL, 32'h2001); wr(A_TRG, 5); wr(A_CTL, 1); wr(A_WPTR, 0);
    push(1, got);
    pulse_trig();
    push(2, got);
    pulse_trig();
    push(20, got);
    chk("R10 second trigger ignored", 32'(got), 32'd3);
    idle(6);
    rd_chk("R9 halt padded", A_WPTR, 32'd8);
    rd_chk("R9 halted", A_FSTAT, 32'h2);
    wr(A_RPTR, 6);
    rd_chk("R10 slot6 is padding", A_RDATA, 32'h0);
  endtask

  task automatic t_trig_nopad();
    int got;
    wr(A_CTL, 0); wr(A_FCTL, 32'h2000); wr(A_TRG, 3); wr(A_CTL, 1); wr(A_WPTR, 0);
    push(2, got);
    pulse_trig();
    push(10, got);
    chk("R9 count 3", 32'(got), 32'd3);
    idle(4);
    rd_chk("R11 no padding", A_WPTR, 32'd5);
    rd_chk("R11 halted", A_FSTAT, 32'h2);
  endtask

  task automatic t_trig_zero();
    int got;
    wr(A_CTL, 0); wr(A_FCTL, 32'h2001); wr(A_TRG, 0); wr(A_CTL, 1); wr(A_WPTR, 0);
    push(4, got);
    pulse_trig();
    push(5, got);
    chk("R9 zero count", 32'(got), 32'd0);
    rd_chk("R9 zero wptr", A_WPTR, 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sw_ram();
    t_capture();
    t_wrap();
    t_flush_stop();
    t_ext_flush();
    t_trig();
    t_trig_nopad();
    t_trig_zero();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule